// File: doc/BRIEF.md
# PCI Initiator Bus-Acquisition and Strobe Sequencer

This block runs the master side of a PCI-style bus for one burst at a time. A one-cycle local `start` pulse, with a burst length, makes it pull the active-low bus request low. It then waits for a clock edge on which the arbiter's grant is low and the bus FRAME sense is high. On that edge it drives FRAME low to open the address phase. After that it walks the data phases with IRDY until the requested number of transfers has completed.

Alongside the standard signals it drives two active-low sideband strobes. One marks the address phase and the other marks each completed data transfer. Simple non-PCI logic can follow the initiator's activity from these two strobes alone. Every output is a register updated on the rising clock edge.

Top module: `pci_init_seq`

## Requirements
- R1: Reset (active-low, asynchronous) forces `req_n`, `frame_n`, `irdy_n`, `astb_n` and `dstb_n` high and leaves the block idle with no request waiting.
- R2: A `start` pulse in idle pulls `req_n` low at the same edge and captures `burst_len`. While a captured request has not yet launched, further `start` pulses are ignored and the captured length is kept.
- R3: A transaction launches only on an edge where the block is requesting, `gnt_n` is low and `frame_in_n` is high. At that edge `frame_n` and `astb_n` both go low.
- R4: `astb_n` stays low for exactly one clock period. At the edge that raises it, `irdy_n` goes low.
- R5: If grant is high (removed) or the bus is busy before FRAME is driven, `req_n` stays low and the block keeps waiting for a launch edge.
- R6: A transfer is an edge on which `irdy_n` and `trdy_n` are both low. `dstb_n` is low during the clock period after each such edge and high in every other period.
- R7: `frame_n` rises at the edge that completes the next-to-last transfer, or at the address-to-data edge for a one-transfer burst. During the final data phase, `frame_n` is high while `irdy_n` is low.
- R8: At the edge completing the final transfer, `irdy_n` rises. `req_n` rises too, unless a new request was captured (earlier or at that edge). In that case `req_n` stays low and the block waits for grant again.
- R9: A `burst_len` of 0 is executed as a one-transfer burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle local transaction request |
| burst_len | input | LEN_W | Number of data transfers (0 means 1) |
| gnt_n | input | 1 | Active-low grant from the arbiter |
| frame_in_n | input | 1 | Sensed bus FRAME (high = idle) |
| trdy_n | input | 1 | Target ready, active low |
| req_n | output | 1 | Active-low bus request |
| frame_n | output | 1 | FRAME drive, active low |
| irdy_n | output | 1 | Initiator ready drive, active low |
| astb_n | output | 1 | Sideband address strobe, active low |
| dstb_n | output | 1 | Sideband data strobe, active low |

## Verification
The bench offers a grant while another master still holds FRAME; a design that checks only the grant would drive FRAME onto a busy bus. It removes the grant while a request waits; a faulty block would drop its request or launch anyway. It holds TRDY low during the address phase, so a design that counted that edge as a transfer would pulse the data strobe too early and end the burst one phase short. Back-to-back requests, one-transfer and zero-length bursts, and a second start issued while a request is waiting all check where FRAME and REQ rise; an off-by-one counter or a pending request that gets overwritten shows up as a wrong edge.

// File: rtl/pci_init_seq.sv
module pci_init_seq #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] burst_len,
  input  logic             gnt_n,
  input  logic             frame_in_n,
  input  logic             trdy_n,
  output logic             req_n,
  output logic             frame_n,
  output logic             irdy_n,
  output logic             astb_n,
  output logic             dstb_n
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ADDR, S_DATA} st_t;

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

  st_t              st;
  logic             pend;
  logic [LEN_W-1:0] plen;
  logic [LEN_W-1:0] cnt;

  wire              launch  = (st == S_WAIT) && !gnt_n && frame_in_n;
  wire              more    = pend || start;
  wire [LEN_W-1:0]  len_fix = (burst_len == '0) ? ONE : burst_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pend    <= 1'b0;
      plen    <= '0;
      cnt     <= '0;
      req_n   <= 1'b1;
      frame_n <= 1'b1;
      irdy_n  <= 1'b1;
      astb_n  <= 1'b1;
      dstb_n  <= 1'b1;
    end else begin
      dstb_n <= irdy_n | trdy_n;

      if (launch) pend <= 1'b0;
      else if (start && !pend) begin
        pend <= 1'b1;
        plen <= len_fix;
      end

      case (st)
        S_IDLE: if (start) begin
          st    <= S_WAIT;
          req_n <= 1'b0;
        end
        S_WAIT: if (launch) begin
          st      <= S_ADDR;
          frame_n <= 1'b0;
          astb_n  <= 1'b0;
          cnt     <= plen;
        end
        S_ADDR: begin
          st      <= S_DATA;
          astb_n  <= 1'b1;
          irdy_n  <= 1'b0;
          frame_n <= (cnt == ONE);
        end
        S_DATA: if (!trdy_n) begin
          if (cnt == ONE) begin
            irdy_n <= 1'b1;
            req_n  <= !more;
            st     <= more ? S_WAIT : S_IDLE;
          end else begin
            cnt <= cnt - ONE;
            if (cnt == TWO) frame_n <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module pci_init_seq_chk #(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] burst_len,
  input logic             gnt_n,
  input logic             frame_in_n,
  input logic             trdy_n,
  input logic             req_n,
  input logic             frame_n,
  input logic             irdy_n,
  input logic             astb_n,
  input logic             dstb_n
);

  assert_launch_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> $past(!gnt_n && frame_in_n && !req_n));

  assert_astb_with_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !astb_n |-> !frame_n);

  assert_astb_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !astb_n |=> (astb_n && !irdy_n));

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && frame_n && irdy_n && gnt_n) |=> !req_n);

  assert_dstb_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !trdy_n) |=> !dstb_n);

  assert_dstb_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy_n || trdy_n) |=> dstb_n);

  assert_irdy_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irdy_n) |-> frame_n);

  assert_req_covers_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> !req_n);

endmodule

bind pci_init_seq pci_init_seq_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_pci_init_seq.sv
`timescale 1ns/1ps
module sim_pci_init_seq;
  localparam int LEN_W = 4;
  localparam int NV = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] burst_len = '0;
  logic gnt_n = 1'b1;
  logic other_frame_n = 1'b1;
  logic trdy_n = 1'b1;
  logic req_n, frame_n, irdy_n, astb_n, dstb_n;
  wire  frame_bus_n = frame_n & other_frame_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pci_init_seq #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .burst_len(burst_len),
    .gnt_n(gnt_n), .frame_in_n(frame_bus_n), .trdy_n(trdy_n),
    .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .astb_n(astb_n), .dstb_n(dstb_n)
  );

  // {start, len[3:0], gnt_n, other_frame_n, trdy_n, req, frame, irdy, astb, dstb}
  localparam logic [12:0] VEC [NV] = '{
    13'b1_0011_111_01111, 13'b0_0000_111_01111, 13'b0_0000_001_01111,
    13'b0_0000_011_00101, 13'b0_0000_111_00011, 13'b0_0000_111_00011,
    13'b0_0000_110_00010, 13'b0_0000_110_01010, 13'b0_0000_110_11110,
    13'b0_0000_111_11111, 13'b1_0001_011_01111, 13'b0_0000_011_00101,
    13'b1_0010_111_01011, 13'b0_0000_110_01110, 13'b0_0000_111_01111,
    13'b0_0000_011_00101, 13'b0_0000_010_00011, 13'b0_0000_110_01010,
    13'b0_0000_110_11110, 13'b0_0000_111_11111, 13'b1_0000_111_01111,
    13'b0_0000_001_01111, 13'b0_0000_111_01111, 13'b0_0000_011_00101,
    13'b0_0000_111_01011, 13'b0_0000_110_11110, 13'b0_0000_111_11111
  };

  function automatic string row_tag(input int i);
    if (i <= 1 || i == 10) return "R2";
    if (i == 2 || i == 3 || i == 21) return "R3";
    if (i == 4) return "R4";
    if (i == 22) return "R5";
    if (i == 7 || i == 11 || i == 12) return "R7";
    if (i == 8 || i == 13 || i == 14) return "R8";
    if (i >= 20) return "R9";
    return "R6";
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: req/frame/irdy/astb/dstb act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {req_n, frame_n, irdy_n, astb_n, dstb_n};
  endfunction

  task automatic cyc(input logic s, input logic [LEN_W-1:0] l, input logic g,
                     input logic o, input logic t);
    @(negedge clk);
    start = s; burst_len = l; gnt_n = g; other_frame_n = o; trdy_n = t;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", outs(), 5'b11111);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][12], VEC[i][11:8], VEC[i][7], VEC[i][6], VEC[i][5]);
      chk(row_tag(i), outs(), VEC[i][4:0]);
    end

    // R2: second start while waiting must not replace captured length 1
    cyc(1'b1, 4'd1, 1'b1, 1'b1, 1'b1);
    cyc(1'b1, 4'd3, 1'b1, 1'b1, 1'b1);
    chk("R2 wait", outs(), 5'b01111);
    cyc(1'b0, 4'd0, 1'b0, 1'b1, 1'b1);
    cyc(1'b0, 4'd0, 1'b1, 1'b1, 1'b1);
    chk("R2 len kept", outs(), 5'b01011);
    cyc(1'b0, 4'd0, 1'b1, 1'b1, 1'b0);
    chk("R2 single", outs(), 5'b11110);
    cyc(1'b0, 4'd0, 1'b1, 1'b1, 1'b1);
    chk("R2 idle", outs(), 5'b11111);

    // R1: reset mid-burst
    cyc(1'b1, 4'd5, 1'b0, 1'b1, 1'b1);
    cyc(1'b0, 4'd0, 1'b0, 1'b1, 1'b1);
    cyc(1'b0, 4'd0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 4'd0, 1'b0, 1'b1, 1'b0);
    chk("R6 mid", outs(), 5'b00010);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async", outs(), 5'b11111);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 4'd0, 1'b0, 1'b1, 1'b0);
    chk("R1 stays idle", outs(), 5'b11111);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule